// File: doc/BRIEF.md
# Vertical Window Controller

This block decides how tightly a vertical count-down divider looks for incoming vertical sync, and which field rate (50 Hz or 60 Hz) it runs at. Once per field, a field-start strobe delivers the divider's coincidence result: whether the incoming vertical pulse fell where the divider expected it. Runs of good results raise the catching window from the wide search window to the narrow window and then to the standard window. Runs of misses lower it one level at a time.

Software has two levers. A force-search control drops the window straight to search, so that vertical catching after a channel change is faster. A two-bit frequency mode chooses the field rate used while the divider is not tracking a locked signal. A phase-loop-off control clears the lock status and at once moves the field rate to the unlocked choice. The measured field rate of the incoming signal is captured only while the window is standard, and is reused by the "keep last" mode.

Top module: `vwin_ctrl`

## Requirements
- R1: After reset, `window_o` is search (2'b00), the captured frequency is 60 Hz, and with `sync_lock_i` low `lock_o` is 0.
- R2: On strobes with `coinc_i`=1, three in a row raise the window one level (search 2'b00 → narrow 2'b01 → standard 2'b10). A missed strobe restarts the run. Two good strobes alone change nothing.
- R3: On strobes with `coinc_i`=0, three in a row lower the window one level, so falling from standard to search takes six missed strobes. A good strobe restarts the miss run.
- R4: Without `field_stb_i`, the window and the captured frequency do not change, whatever the other inputs do.
- R5: A strobe with `search_force_i`=1 sets the window to search and clears both runs, whatever the value of `coinc_i`. While the control is held, the window stays in search.
- R6: When `freq_mode_i`=2'b01, `field_50_o` is 0 (60 Hz) in the same cycle. No strobe is needed.
- R7: When the divider is not tracking, `freq_mode_i` selects the rate: 2'b00 gives 60 Hz, 2'b11 gives 50 Hz, and 2'b10 gives the last captured rate.
- R8: `det_50hz_i` is captured only on a strobe after which the window is standard. While tracking (window standard, `sync_lock_i`=1, `phase_off_i`=0), `field_50_o` equals the captured rate.
- R9: `phase_off_i`=1 forces `lock_o` to 0 and moves `field_50_o` to the unlocked choice of R7 in the same cycle.
- R10: `window_o` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| field_stb_i | input | 1 | One-cycle field-start strobe; all state updates happen on it |
| coinc_i | input | 1 | Coincidence result for this field (1 = good) |
| sync_lock_i | input | 1 | Sync-lock indication from the phase loop |
| det_50hz_i | input | 1 | Measured field rate of the input (1 = 50 Hz) |
| search_force_i | input | 1 | Force the search window |
| freq_mode_i | input | 2 | Field-rate mode: 00 auto/60, 01 forced 60, 10 keep last, 11 auto/50 |
| phase_off_i | input | 1 | Phase loop off: clears lock and takes the unlocked rate |
| window_o | output | 2 | Window: 00 search, 01 narrow, 10 standard |
| field_50_o | output | 1 | Selected field rate (1 = 50 Hz, 0 = 60 Hz) |
| lock_o | output | 1 | Lock status |

## Verification
The hardest situation to reach is the "keep last" rate after the window has fallen out of standard. In that state the output depends on a value captured many fields earlier, and the value on `det_50hz_i` at that moment must not be taken. The stimulus climbs to standard with a 50 Hz measurement and forces search. It then changes the measurement to 60 Hz while feeding missed strobes, and shows that the output still reports the old 50 Hz capture. The exact-count boundaries are covered as well: the second good strobe and the second miss must not move the window, while the third must.

// File: rtl/vwin_pkg.sv
package vwin_pkg;
  typedef enum logic [1:0] {
    WIN_SEARCH = 2'b00,
    WIN_NARROW = 2'b01,
    WIN_STD    = 2'b10
  } win_e;

  typedef enum logic [1:0] {
    FM_AUTO60  = 2'b00,
    FM_FORCE60 = 2'b01,
    FM_KEEP    = 2'b10,
    FM_AUTO50  = 2'b11
  } fmode_e;

  function automatic win_e win_up(input win_e w);
    case (w)
      WIN_SEARCH: win_up = WIN_NARROW;
      default:    win_up = WIN_STD;
    endcase
  endfunction

  function automatic win_e win_down(input win_e w);
    case (w)
      WIN_STD: win_down = WIN_NARROW;
      default: win_down = WIN_SEARCH;
    endcase
  endfunction
endpackage

// File: rtl/vwin_level_fsm.sv
module vwin_level_fsm
  import vwin_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int UP_RUN   = 3,
  parameter int DOWN_RUN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic field_stb_i,
  input  logic coinc_i,
  input  logic search_force_i,
  output win_e level_o,
  output logic capture_o
);
  localparam logic [CNT_W-1:0] UP_LAST   = CNT_W'(UP_RUN - 1);
  localparam logic [CNT_W-1:0] DOWN_LAST = CNT_W'(DOWN_RUN - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  win_e             level_q, level_d;
  logic [CNT_W-1:0] hit_q, hit_d, miss_q, miss_d;

  always_comb begin
    level_d = level_q;
    hit_d   = hit_q;
    miss_d  = miss_q;
    if (field_stb_i) begin
      if (search_force_i) begin
        level_d = WIN_SEARCH;
        hit_d   = '0;
        miss_d  = '0;
      end else if (coinc_i) begin
        miss_d = '0;
        if (level_q == WIN_STD) begin
          hit_d = '0;
        end else if (hit_q == UP_LAST) begin
          hit_d   = '0;
          level_d = win_up(level_q);
        end else begin
          hit_d = hit_q + ONE;
        end
      end else begin
        hit_d = '0;
        if (level_q == WIN_SEARCH) begin
          miss_d = '0;
        end else if (miss_q == DOWN_LAST) begin
          miss_d  = '0;
          level_d = win_down(level_q);
        end else begin
          miss_d = miss_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= WIN_SEARCH;
      hit_q   <= '0;
      miss_q  <= '0;
    end else begin
      level_q <= level_d;
      hit_q   <= hit_d;
      miss_q  <= miss_d;
    end
  end

  assign level_o   = level_q;
  assign capture_o = field_stb_i && (level_d == WIN_STD);

  assert_hold_no_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_stb_i |=> $stable(level_q));
  assert_force_search_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_stb_i && search_force_i) |=> (level_q == WIN_SEARCH));
  assert_one_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == WIN_SEARCH) |=> (level_q != WIN_STD));
  assert_legal_level_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q != 2'b11);
endmodule

// File: rtl/vwin_freq_sel.sv
module vwin_freq_sel
  import vwin_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       capture_i,
  input  logic       det_50hz_i,
  input  logic       tracking_i,
  input  logic [1:0] freq_mode_i,
  output logic       field_50_o
);
  logic   det_q;
  fmode_e fmode;

  assign fmode = fmode_e'(freq_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        det_q <= 1'b0;
    else if (capture_i) det_q <= det_50hz_i;
  end

  always_comb begin
    case (fmode)
      FM_FORCE60: field_50_o = 1'b0;
      FM_KEEP:    field_50_o = det_q;
      FM_AUTO50:  field_50_o = tracking_i ? det_q : 1'b1;
      default:    field_50_o = tracking_i ? det_q : 1'b0;
    endcase
  end

  assert_capture_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(det_q));
endmodule

// File: rtl/vwin_ctrl.sv
module vwin_ctrl
  import vwin_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int UP_RUN   = 3,
  parameter int DOWN_RUN = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       field_stb_i,
  input  logic       coinc_i,
  input  logic       sync_lock_i,
  input  logic       det_50hz_i,
  input  logic       search_force_i,
  input  logic [1:0] freq_mode_i,
  input  logic       phase_off_i,
  output logic [1:0] window_o,
  output logic       field_50_o,
  output logic       lock_o
);
  win_e level;
  logic capture, tracking;

  vwin_level_fsm #(
    .CNT_W   (CNT_W),
    .UP_RUN  (UP_RUN),
    .DOWN_RUN(DOWN_RUN)
  ) u_level (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .field_stb_i   (field_stb_i),
    .coinc_i       (coinc_i),
    .search_force_i(search_force_i),
    .level_o       (level),
    .capture_o     (capture)
  );

  assign lock_o   = sync_lock_i && !phase_off_i;
  assign tracking = lock_o && (level == WIN_STD);

  vwin_freq_sel u_freq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture),
    .det_50hz_i (det_50hz_i),
    .tracking_i (tracking),
    .freq_mode_i(freq_mode_i),
    .field_50_o (field_50_o)
  );

  assign window_o = level;

  assert_forced_60_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_mode_i == 2'b01) |-> !field_50_o);
  assert_off_auto60_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_off_i && freq_mode_i == 2'b00) |-> !field_50_o);
  assert_off_auto50_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_off_i && freq_mode_i == 2'b11) |-> field_50_o);
endmodule

// File: tb/vwin_ctrl_tb.sv
module vwin_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0, coinc = 1'b0, slock = 1'b0, det50 = 1'b0;
  logic       force_s = 1'b0, poff = 1'b0;
  logic [1:0] fmode = 2'b00;
  logic [1:0] win;
  logic       f50, lock;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vwin_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .field_stb_i(stb), .coinc_i(coinc),
    .sync_lock_i(slock), .det_50hz_i(det50), .search_force_i(force_s),
    .freq_mode_i(fmode), .phase_off_i(poff),
    .window_o(win), .field_50_o(f50), .lock_o(lock)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic field(input logic c);
    @(negedge clk); coinc = c; stb = 1'b1;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R1 window", win, 0);
    chk("R1 field_50", f50, 0);
    chk("R1 lock", lock, 0);
  endtask

  task automatic t_climb;
    field(1); field(1);
    chk("R2 two hits stay search", win, 0);
    field(0); field(1); field(1);
    chk("R2 miss restarts run", win, 0);
    field(1);
    chk("R2 third hit narrow", win, 1);
    field(1); field(1); field(1);
    chk("R2 reach standard", win, 2);
  endtask

  task automatic t_hold;
    coinc = 1'b0; det50 = 1'b1; force_s = 1'b1;
    repeat (8) @(negedge clk);
    chk("R4 window stable", win, 2);
    force_s = 1'b0; det50 = 1'b0;
  endtask

  task automatic t_drop;
    field(0); field(0); field(1); field(0); field(0);
    chk("R3 hit restarts miss run", win, 2);
    field(0);
    chk("R3 third miss narrow", win, 1);
    field(0); field(0);
    chk("R3 two misses stay narrow", win, 1);
    field(0);
    chk("R3 six misses search", win, 0);
  endtask

  task automatic t_force;
    repeat (6) field(1);
    chk("R5 pre standard", win, 2);
    force_s = 1'b1;
    field(1);
    chk("R5 forced search", win, 0);
    repeat (4) field(1);
    chk("R5 held search", win, 0);
    force_s = 1'b0;
  endtask

  task automatic t_capture;
    slock = 1'b1; det50 = 1'b1; fmode = 2'b00;
    repeat (6) field(1);
    chk("R8 tracking 50", f50, 1);
    chk("R8 lock", lock, 1);
    det50 = 1'b0; repeat (4) @(negedge clk);
    chk("R8 no capture without strobe", f50, 1);
    field(1);
    chk("R8 capture 60", f50, 0);
    det50 = 1'b1; field(1);
    chk("R8 capture 50", f50, 1);
  endtask

  task automatic t_force60_off;
    fmode = 2'b01; #1;
    chk("R6 forced 60 same cycle", f50, 0);
    fmode = 2'b00; #1;
    chk("R6 release", f50, 1);
    poff = 1'b1; #1;
    chk("R9 lock cleared", lock, 0);
    chk("R9 auto60", f50, 0);
    fmode = 2'b11; #1;
    chk("R9 auto50", f50, 1);
    poff = 1'b0; fmode = 2'b00; #1;
    chk("R9 release lock", lock, 1);
  endtask

  task automatic t_unlocked;
    force_s = 1'b1; field(1); force_s = 1'b0;
    det50 = 1'b0;
    field(0); field(0); field(0);
    chk("R8 no capture in search", win, 0);
    fmode = 2'b10; #1;
    chk("R7 keep last 50", f50, 1);
    fmode = 2'b00; #1;
    chk("R7 auto 60", f50, 0);
    fmode = 2'b11; #1;
    chk("R7 auto 50", f50, 1);
    chk("R10 legal code", (win == 2'b11) ? 1 : 0, 0);
  endtask

  initial begin
    t_reset;
    t_climb;
    t_hold;
    t_drop;
    t_force;
    t_capture;
    t_force60_off;
    t_unlocked;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule